// File: doc/BRIEF.md
# Duty-Cycled Omnipolar Magnetic Switch Controller

This block holds the timing and decision logic of a low-power magnetic presence switch. A free-running timer counts cycles of a 1 MHz reference clock. At the start of every period it enables the sensing front end for a short awake window, and it disables the front end for the rest of the period. In the last cycle of the awake window the block reads a signed field sample, which is already settled. It then makes an omnipolar hysteresis decision: a strong field of either polarity turns the switch on. The result goes into an output latch that holds through the whole sleep phase and drives an active-low output.

The field sample is a plain level, not a stream. The front end keeps it steady while it is enabled, and the block reads it once per period. For that reason it has no valid/ready pair and applies no back-pressure. Four signed thresholds are held in registers that reset to the typical switch points. A single write strobe reloads all four, and the new values are used at the next decision. A mode input chooses a short or a long period. A change on that input is picked up only at a period boundary.

Top module: `omni_switch_ctrl`

## Requirements
- R1: After reset the output is off (`out_n` = 1), the front end is enabled, and the first period runs in fast mode.
- R2: Every period starts with exactly AWAKE_TICKS (default 60) cycles with `fe_en` = 1, followed by sleep cycles with `fe_en` = 0.
- R3: In fast mode (`slow_mode` = 0) a period lasts FAST_TICKS (default 240) cycles. In slow mode (`slow_mode` = 1) it lasts SLOW_TICKS (default 60000) cycles.
- R4: `slow_mode` is sampled only at the end of a period. A change made during a period leaves that period's length unchanged.
- R5: `field` is used only in the last awake cycle. `out_n` can change only on the clock edge where `fe_en` falls, and it holds its value through sleep and the next awake window.
- R6: While the switch is off, it turns on when the field is strictly greater than the south operate threshold or strictly less than the north operate threshold. A value equal to a threshold does not turn it on.
- R7: While the switch is on, it turns off only when the field lies strictly between the north release and south release thresholds. A field of either polarity outside that band keeps it on.
- R8: Fields and thresholds are 16-bit two's-complement values in units of 0.1 G, compared as signed numbers. The reset defaults are: south operate 420, south release 320, north operate -480, north release -380.
- R9: A one-cycle `thr_wr` pulse loads all four threshold inputs into the threshold registers. The loaded values govern the next decision.
- R10: `out_n` is 0 when the switch is on and 1 when it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz reference clock |
| rst_n | input | 1 | Active-low reset |
| slow_mode | input | 1 | Period select: 1 = slow, 0 = fast |
| thr_wr | input | 1 | Load strobe for the four thresholds |
| thr_op_s | input | 16 | South operate threshold (signed) |
| thr_rel_s | input | 16 | South release threshold (signed) |
| thr_op_n | input | 16 | North operate threshold (signed) |
| thr_rel_n | input | 16 | North release threshold (signed) |
| field | input | 16 | Signed field sample from the front end |
| fe_en | output | 1 | Front-end enable, high during the awake window |
| out_n | output | 1 | Active-low switch output |

## Verification
A cycle counter that is off by one would show as an awake window or a period that is one cycle long or short. This shows up within a single period of counting `fe_en`, so window and period lengths are measured exactly. A wrong hysteresis state would show as the switch turning off inside a band where it should hold, or turning on at a value exactly on a threshold, and this appears at the first window after that field is applied. Sampling at the wrong moment would let a field applied only during sleep, or removed before the last awake cycle, change `out_n`. The bench applies fields in exactly those places.

// File: rtl/omni_switch_pkg.sv
package omni_switch_pkg;
  localparam int FIELD_W = 16;
  typedef logic signed [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t op_s;
    field_t rel_s;
    field_t op_n;
    field_t rel_n;
  } thr_set_t;

  localparam field_t DEF_OP_S  = 16'sd420;
  localparam field_t DEF_REL_S = 16'sd320;
  localparam field_t DEF_OP_N  = -16'sd480;
  localparam field_t DEF_REL_N = -16'sd380;
endpackage

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int AWAKE_TICKS = 60,
  parameter int FAST_TICKS  = 240,
  parameter int SLOW_TICKS  = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_req,
  output logic fe_en,
  output logic strobe
);
  localparam int CW = $clog2(SLOW_TICKS + 1);
  localparam logic [CW-1:0] FAST_LAST  = CW'(FAST_TICKS - 1);
  localparam logic [CW-1:0] SLOW_LAST  = CW'(SLOW_TICKS - 1);
  localparam logic [CW-1:0] AWAKE_END  = CW'(AWAKE_TICKS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          cur_slow;

  assign last = cur_slow ? SLOW_LAST : FAST_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_slow <= 1'b0;
    end else if (cnt == last) begin
      cnt      <= '0;
      cur_slow <= slow_req;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fe_en  = (cnt < AWAKE_END);
  assign strobe = (cnt == AWAKE_END - 1'b1);

  // R4
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_slow) |-> (cnt == '0));

  // R2
  window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_en) |-> $past(strobe));

  // R2
  window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_en) |-> (cnt == '0));
endmodule

// File: rtl/omni_decide.sv
module omni_decide
  import omni_switch_pkg::*;
(
  input  logic     cur_on,
  input  field_t   sample,
  input  thr_set_t thr,
  output logic     next_on
);
  logic beyond_op;
  logic inside_rel;

  assign beyond_op  = (sample > thr.op_s) || (sample < thr.op_n);
  assign inside_rel = (sample < thr.rel_s) && (sample > thr.rel_n);

  always_comb begin
    if (cur_on) next_on = !inside_rel;
    else        next_on = beyond_op;
  end
endmodule

// File: rtl/omni_switch_ctrl.sv
module omni_switch_ctrl
  import omni_switch_pkg::*;
#(
  parameter int AWAKE_TICKS = 60,
  parameter int FAST_TICKS  = 240,
  parameter int SLOW_TICKS  = 60000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_mode,
  input  logic               thr_wr,
  input  logic signed [15:0] thr_op_s,
  input  logic signed [15:0] thr_rel_s,
  input  logic signed [15:0] thr_op_n,
  input  logic signed [15:0] thr_rel_n,
  input  logic signed [15:0] field,
  output logic               fe_en,
  output logic               out_n
);
  thr_set_t thr_q;
  logic     strobe;
  logic     on_q;
  logic     on_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '{op_s: DEF_OP_S, rel_s: DEF_REL_S, op_n: DEF_OP_N, rel_n: DEF_REL_N};
    end else if (thr_wr) begin
      thr_q <= '{op_s: thr_op_s, rel_s: thr_rel_s, op_n: thr_op_n, rel_n: thr_rel_n};
    end
  end

  wake_timer #(
    .AWAKE_TICKS(AWAKE_TICKS),
    .FAST_TICKS (FAST_TICKS),
    .SLOW_TICKS (SLOW_TICKS)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow_req(slow_mode),
    .fe_en   (fe_en),
    .strobe  (strobe)
  );

  omni_decide i_decide (
    .cur_on (on_q),
    .sample (field),
    .thr    (thr_q),
    .next_on(on_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      on_q <= 1'b0;
    else if (strobe) on_q <= on_d;
  end

  assign out_n = !on_q;

  // R5
  latch_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_n) |-> $fell(fe_en));

  // R6
  turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_n) |-> (($past(field) > $past(thr_q.op_s)) || ($past(field) < $past(thr_q.op_n))));

  // R7
  turn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_n) |-> (($past(field) < $past(thr_q.rel_s)) && ($past(field) > $past(thr_q.rel_n))));
endmodule

// File: tb/test_omni_switch_ctrl.sv
module test_omni_switch_ctrl;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               slow_mode = 1'b0;
  logic               thr_wr = 1'b0;
  logic signed [15:0] thr_op_s = '0, thr_rel_s = '0, thr_op_n = '0, thr_rel_n = '0;
  logic signed [15:0] field = '0;
  logic               fe_en, out_n;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  omni_switch_ctrl i_omni_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .thr_wr(thr_wr),
    .thr_op_s(thr_op_s), .thr_rel_s(thr_rel_s), .thr_op_n(thr_op_n),
    .thr_rel_n(thr_rel_n), .field(field), .fe_en(fe_en), .out_n(out_n)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic to_awake_start();
    @(negedge clk);
    while (fe_en) @(negedge clk);
    while (!fe_en) @(negedge clk);
  endtask

  task automatic to_sleep_start();
    while (fe_en) @(negedge clk);
  endtask

  // one awake window with a given field; out_n checked after the window ends
  task automatic window(input int f, input int exp_out, input string req);
    to_awake_start();
    field = 16'(f);
    to_sleep_start();
    check(req, out_n, exp_out);
  endtask

  task automatic t_reset();
    check("R1 out_n after reset", out_n, 1);
    check("R1 fe_en after reset", fe_en, 1);
  endtask

  task automatic t_timing();
    int a, s;
    to_awake_start();
    a = 0;
    while (fe_en) begin a++; @(negedge clk); end
    s = 0;
    while (!fe_en) begin s++; @(negedge clk); end
    check("R2 awake cycles", a, 60);
    check("R3 fast period", a + s, 240);
  endtask

  task automatic t_south();
    window(420, 1, "R6 equal to south operate stays off");
    window(500, 0, "R6 south above operate turns on");
    window(350, 0, "R7 south in hysteresis stays on");
    window(-500, 0, "R7 opposite pole keeps on");
    window(310, 1, "R7 below south release turns off");
  endtask

  task automatic t_north();
    window(-450, 1, "R8 weak north stays off");
    window(-490, 0, "R6 north below operate turns on");
    window(-400, 0, "R7 north in hysteresis stays on");
    window(-380, 0, "R7 equal to north release stays on");
    window(-370, 1, "R7 above north release turns off");
  endtask

  task automatic t_sample_point();
    bit changed;
    to_awake_start();
    field = 16'sd0;
    to_sleep_start();
    field = 16'sd900;
    changed = 1'b0;
    while (!fe_en) begin if (out_n !== 1'b1) changed = 1'b1; @(negedge clk); end
    check("R5 sleep field ignored", changed, 0);
    repeat (30) begin if (out_n !== 1'b1) changed = 1'b1; @(negedge clk); end
    field = 16'sd0;
    check("R5 held in awake window", changed, 0);
    to_sleep_start();
    check("R5 only last awake sample counts", out_n, 1);
    window(900, 0, "R10 on drives out_n low");
    changed = 1'b0;
    field = 16'sd0;
    while (!fe_en) begin if (out_n !== 1'b0) changed = 1'b1; @(negedge clk); end
    check("R5 on held through sleep", changed, 0);
    to_sleep_start();
    check("R10 off releases out_n high", out_n, 1);
  endtask

  task automatic t_thresholds();
    @(negedge clk);
    thr_op_s = 16'sd100; thr_rel_s = 16'sd50;
    thr_op_n = -16'sd100; thr_rel_n = -16'sd50;
    thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0;
    thr_op_s = 16'sd2000;
    window(150, 0, "R9 loaded south operate");
    window(60, 0, "R9 loaded south release holds");
    window(40, 1, "R9 loaded south release off");
    window(-101, 0, "R9 loaded north operate");
  endtask

  task automatic t_slow();
    int a, s;
    to_awake_start();
    slow_mode = 1'b1;
    a = 0;
    while (fe_en) begin a++; @(negedge clk); end
    s = 0;
    while (!fe_en) begin s++; @(negedge clk); end
    check("R4 current period unchanged", a + s, 240);
    a = 0;
    while (fe_en) begin a++; @(negedge clk); end
    s = 0;
    while (!fe_en) begin s++; @(negedge clk); end
    check("R2 awake in slow mode", a, 60);
    check("R3 slow period", a + s, 60000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_south();
    t_north();
    t_sample_point();
    t_thresholds();
    t_slow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule